// File: doc/BRIEF.md
# Power Stage Fault Supervisor

This block is the digital fault supervisor of a synchronous buck power stage. It watches comparator flags from the analog side: one supply-good flag for the logic supply and one for the input supply, a high-side overcurrent comparator, and a comparator that trips when the switch node sits high. It also watches an 8-bit junction temperature code, the decoded PWM input level and the present state of both gate drives. From these it decides when the stage may operate and which faults are active.

It drives five outputs: a ready flag that marks the end of power-on reset, a request that holds the high-side gate off, two overrides that pin the current-monitor and temperature-monitor outputs to their fault levels, and an active-low fault line.

An overcurrent fault clears only through an acknowledge handshake. The controller does this by holding its PWM output at the mid level for a set time. A shorted high-side FET fault stays latched until the logic supply goes through reset again. Over-temperature uses set and clear thresholds with hysteresis and never acts on the gates.

Top module: `pstage_fault_sup`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled high, `por_ready`, `imon_force`, `tmon_force` and `fault_n` are 0 and `gh_block` is 1.
- R2: `por_ready` becomes 1 after the POR_CYC-th consecutive rising edge at which `vcc_ok` is sampled high. It becomes 0 after the first edge at which `vcc_ok` is sampled low, and the count then starts again from zero.
- R3: At an edge where `gh_on`, `oc_cmp`, `vcc_ok` and `vin_ok` are all 1, an overcurrent fault is set. After that edge `imon_force` is 1, `gh_block` is 1 and `fault_n` is 0, whatever `pwm_lvl` is. If any one of `gh_on`, `vcc_ok` or `vin_ok` is 0, `oc_cmp` has no effect.
- R4: An overcurrent fault clears after ACK_CYC consecutive edges at which `pwm_lvl` is the mid level. The mid level is code 2'b10, and the floating code 2'b11 also counts as mid. Code 2'b00 is low and 2'b01 is high. Any edge at another level restarts the count. Without the acknowledge, the fault and the gate block stay set indefinitely.
- R5: At an edge where `sw_hi`, `gl_on` and `vcc_ok` are all 1, a shorted-FET fault is latched. It drives `imon_force` and `gh_block` to 1 and is unaffected by a PWM acknowledge. It clears only when `vcc_ok` is sampled low or `rst` is applied.
- R6: After an edge where `temp_c` is at least 140, `tmon_force` is 1. After an edge where `temp_c` is below 125, it is 0. For codes from 125 to 139 it keeps its previous value. The over-temperature state never changes `gh_block`.
- R7: `fault_n` is 1 only when `por_ready` is 1, `vin_ok` was 1 at the last edge, and no overcurrent, shorted-FET or over-temperature fault is active.
- R8: `gh_block` is 1 exactly when `por_ready` is 0 or an overcurrent or shorted-FET fault is active.
- R9: Sampling `vcc_ok` low also clears a pending overcurrent fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_ok | input | 1 | Logic supply above its reset level |
| vin_ok | input | 1 | Input supply above its reset level |
| oc_cmp | input | 1 | High-side current above its limit |
| sw_hi | input | 1 | Switch node above its short-detect level |
| temp_c | input | 8 | Junction temperature, unsigned degrees C |
| pwm_lvl | input | 2 | Decoded PWM level: 00 low, 01 high, 10 mid, 11 floating |
| gh_on | input | 1 | High-side gate currently on |
| gl_on | input | 1 | Low-side gate currently on |
| por_ready | output | 1 | Power-on reset complete |
| gh_block | output | 1 | Hold the high-side gate off |
| imon_force | output | 1 | Pull the current monitor to its fault level |
| tmon_force | output | 1 | Pull the temperature monitor to its fault level |
| fault_n | output | 1 | Active-low fault indication |

## Verification
Every fault flag drives a port one edge after its cause, so a fault bit in the wrong state shows on `imon_force`, `tmon_force`, `gh_block` or `fault_n` within one cycle. An acknowledge counter that miscounts shows as a clear one edge too early or too late. This is checked at both ends of the window, and again after the window is interrupted. A hysteresis bit that has lost its value shows while the temperature code is swept up and then down through the 125 to 139 band. A power-on counter that is off by one shows on `por_ready` in a cycle-by-cycle sweep after each supply return.

// File: rtl/pstage_fault_pkg.sv
package pstage_fault_pkg;

  // PWM level codes as seen by the supervisor
  typedef enum logic [1:0] {
    PWM_LOW   = 2'b00,
    PWM_HIGH  = 2'b01,
    PWM_MID   = 2'b10,
    PWM_FLOAT = 2'b11
  } pwm_lvl_e;

  // A floating input is pulled into the mid window, so both count as mid
  function automatic logic pwm_is_mid(input logic [1:0] lvl);
    return (lvl == PWM_MID) || (lvl == PWM_FLOAT);
  endfunction

endpackage

// File: rtl/pstage_por_timer.sv
module pstage_por_timer #(
  parameter int POR_CYC = 6250
) (
  input  logic clk,
  input  logic rst,
  input  logic vcc_ok,
  output logic ready
);
  localparam int CW = $clog2(POR_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(POR_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !vcc_ok) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      if (cnt == LAST) ready <= 1'b1;
      else             cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pstage_oc_ctrl.sv
module pstage_oc_ctrl
  import pstage_fault_pkg::*;
#(
  parameter int ACK_CYC = 50
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vcc_ok,
  input  logic       vin_ok,
  input  logic       gh_on,
  input  logic       oc_cmp,
  input  logic [1:0] pwm_lvl,
  output logic       oc_flt
);
  localparam int AW = $clog2(ACK_CYC + 1);
  localparam logic [AW-1:0] ACK_LAST = AW'(ACK_CYC - 1);

  logic [AW-1:0] ack_cnt;
  logic          armed_trip;
  logic          ack_lvl;

  // Detection is armed only while the high side conducts on good supplies
  assign armed_trip = gh_on && oc_cmp && vcc_ok && vin_ok;
  assign ack_lvl    = pwm_is_mid(pwm_lvl);

  always_ff @(posedge clk) begin
    if (rst || !vcc_ok) begin
      oc_flt  <= 1'b0;
      ack_cnt <= '0;
    end else if (armed_trip) begin
      oc_flt  <= 1'b1;
      ack_cnt <= '0;
    end else if (oc_flt && ack_lvl) begin
      if (ack_cnt == ACK_LAST) begin
        oc_flt  <= 1'b0;
        ack_cnt <= '0;
      end else begin
        ack_cnt <= ack_cnt + 1'b1;
      end
    end else begin
      ack_cnt <= '0;
    end
  end
endmodule

// File: rtl/pstage_short_latch.sv
module pstage_short_latch (
  input  logic clk,
  input  logic rst,
  input  logic vcc_ok,
  input  logic sw_hi,
  input  logic gl_on,
  output logic short_flt
);
  // Switch node high while the low side conducts means the high side is shorted
  always_ff @(posedge clk) begin
    if (rst || !vcc_ok)       short_flt <= 1'b0;
    else if (sw_hi && gl_on)  short_flt <= 1'b1;
  end
endmodule

// File: rtl/pstage_ot_hyst.sv
module pstage_ot_hyst #(
  parameter int TEMP_W = 8,
  parameter int OT_SET = 140,
  parameter int OT_CLR = 125
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TEMP_W-1:0] temp_c,
  output logic              ot_flt
);
  localparam logic [TEMP_W-1:0] SET_CODE = TEMP_W'(OT_SET);
  localparam logic [TEMP_W-1:0] CLR_CODE = TEMP_W'(OT_CLR);

  always_ff @(posedge clk) begin
    if (rst)                      ot_flt <= 1'b0;
    else if (temp_c >= SET_CODE)  ot_flt <= 1'b1;
    else if (temp_c <  CLR_CODE)  ot_flt <= 1'b0;
  end
endmodule

// File: rtl/pstage_fault_sup.sv
module pstage_fault_sup
  import pstage_fault_pkg::*;
#(
  parameter int POR_CYC = 6250,
  parameter int ACK_CYC = 50,
  parameter int TEMP_W  = 8,
  parameter int OT_SET  = 140,
  parameter int OT_CLR  = 125
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vcc_ok,
  input  logic              vin_ok,
  input  logic              oc_cmp,
  input  logic              sw_hi,
  input  logic [TEMP_W-1:0] temp_c,
  input  logic [1:0]        pwm_lvl,
  input  logic              gh_on,
  input  logic              gl_on,
  output logic              por_ready,
  output logic              gh_block,
  output logic              imon_force,
  output logic              tmon_force,
  output logic              fault_n
);
  logic ready_q;
  logic oc_q;
  logic short_q;
  logic ot_q;
  logic vin_q;

  pstage_por_timer #(.POR_CYC(POR_CYC)) u_por (
    .clk(clk), .rst(rst), .vcc_ok(vcc_ok), .ready(ready_q)
  );

  pstage_oc_ctrl #(.ACK_CYC(ACK_CYC)) u_oc (
    .clk(clk), .rst(rst), .vcc_ok(vcc_ok), .vin_ok(vin_ok),
    .gh_on(gh_on), .oc_cmp(oc_cmp), .pwm_lvl(pwm_lvl), .oc_flt(oc_q)
  );

  pstage_short_latch u_short (
    .clk(clk), .rst(rst), .vcc_ok(vcc_ok), .sw_hi(sw_hi),
    .gl_on(gl_on), .short_flt(short_q)
  );

  pstage_ot_hyst #(.TEMP_W(TEMP_W), .OT_SET(OT_SET), .OT_CLR(OT_CLR)) u_ot (
    .clk(clk), .rst(rst), .temp_c(temp_c), .ot_flt(ot_q)
  );

  // Input supply flag registered so no input reaches an output combinationally
  always_ff @(posedge clk) begin
    if (rst) vin_q <= 1'b0;
    else     vin_q <= vin_ok;
  end

  // Outputs decode registered state only
  assign por_ready  = ready_q;
  assign gh_block   = !ready_q || oc_q || short_q;
  assign imon_force = oc_q || short_q;
  assign tmon_force = ot_q;
  assign fault_n    = ready_q && vin_q && !oc_q && !short_q && !ot_q;
endmodule

// File: rtl/pstage_fault_sup_chk.sv
module pstage_fault_sup_chk #(
  parameter int TEMP_W = 8,
  parameter int OT_SET = 140,
  parameter int OT_CLR = 125
) (
  input logic              clk,
  input logic              rst,
  input logic              vcc_ok,
  input logic              vin_ok,
  input logic              oc_cmp,
  input logic              gh_on,
  input logic [TEMP_W-1:0] temp_c,
  input logic [1:0]        pwm_lvl,
  input logic              por_ready,
  input logic              gh_block,
  input logic              imon_force,
  input logic              tmon_force,
  input logic              fault_n
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!por_ready && gh_block && !imon_force && !tmon_force && !fault_n)); // R1

  AST_POR_DROP: assert property (@(posedge clk) disable iff (rst)
    !vcc_ok |=> !por_ready); // R2

  AST_OC_TRIP: assert property (@(posedge clk) disable iff (rst)
    (gh_on && oc_cmp && vcc_ok && vin_ok) |=> (imon_force && gh_block && !fault_n)); // R3

  AST_NO_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (imon_force && vcc_ok && (pwm_lvl[1] == 1'b0)) |=> imon_force); // R4

  AST_OT_SET: assert property (@(posedge clk) disable iff (rst)
    (temp_c >= TEMP_W'(OT_SET)) |=> tmon_force); // R6

  AST_OT_CLR: assert property (@(posedge clk) disable iff (rst)
    (temp_c < TEMP_W'(OT_CLR)) |=> !tmon_force); // R6

  AST_FAULT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    fault_n |-> (por_ready && !imon_force && !tmon_force && !gh_block)); // R7

  AST_VCC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !vcc_ok |=> (!imon_force && gh_block)); // R9
endmodule

bind pstage_fault_sup pstage_fault_sup_chk #(
  .TEMP_W(TEMP_W), .OT_SET(OT_SET), .OT_CLR(OT_CLR)
) u_chk (
  .clk(clk), .rst(rst), .vcc_ok(vcc_ok), .vin_ok(vin_ok), .oc_cmp(oc_cmp),
  .gh_on(gh_on), .temp_c(temp_c), .pwm_lvl(pwm_lvl), .por_ready(por_ready),
  .gh_block(gh_block), .imon_force(imon_force), .tmon_force(tmon_force),
  .fault_n(fault_n)
);

// File: tb/pstage_fault_sup_bench.sv
module pstage_fault_sup_bench;
  import pstage_fault_pkg::*;

  localparam int POR_CYC = 16;
  localparam int ACK_CYC = 8;

  logic       clk = 1'b0;
  logic       rst, vcc_ok, vin_ok, oc_cmp, sw_hi, gh_on, gl_on;
  logic [7:0] temp_c;
  logic [1:0] pwm_lvl;
  logic       por_ready, gh_block, imon_force, tmon_force, fault_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pstage_fault_sup #(.POR_CYC(POR_CYC), .ACK_CYC(ACK_CYC)) u_pstage_fault_sup (
    .clk(clk), .rst(rst), .vcc_ok(vcc_ok), .vin_ok(vin_ok), .oc_cmp(oc_cmp),
    .sw_hi(sw_hi), .temp_c(temp_c), .pwm_lvl(pwm_lvl), .gh_on(gh_on),
    .gl_on(gl_on), .por_ready(por_ready), .gh_block(gh_block),
    .imon_force(imon_force), .tmon_force(tmon_force), .fault_n(fault_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock edge, then settle away from the edge before sampling
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic repower();
    vcc_ok = 1'b1;
    for (int i = 1; i <= POR_CYC; i++) begin
      tick();
      check("R2 por count", por_ready, (i >= POR_CYC) ? 1 : 0);
    end
  endtask

  task automatic ack_clear(input string req);
    pwm_lvl = PWM_MID;
    repeat (ACK_CYC - 1) tick();
    check({req, " held before window ends"}, imon_force, 1);
    tick();
    check({req, " cleared at window end"}, imon_force, 0);
    pwm_lvl = PWM_LOW;
  endtask

  task automatic trip_oc();
    gh_on = 1'b1; oc_cmp = 1'b1; pwm_lvl = PWM_HIGH;
    tick();
    gh_on = 1'b0; oc_cmp = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; vcc_ok = 1'b0; vin_ok = 1'b0; oc_cmp = 1'b0; sw_hi = 1'b0;
    gh_on = 1'b0; gl_on = 1'b0; temp_c = 8'd25; pwm_lvl = PWM_LOW;
    #3;
    tick(); tick();
    check("R1 por_ready", por_ready, 0);
    check("R1 gh_block", gh_block, 1);
    check("R1 imon_force", imon_force, 0);
    check("R1 tmon_force", tmon_force, 0);
    check("R1 fault_n", fault_n, 0);

    // R2 power-on sweep
    rst = 1'b0; vin_ok = 1'b1;
    repower();
    check("R7 released", fault_n, 1);
    check("R8 no block when ready", gh_block, 0);

    // R2 interrupted count restarts from zero
    vcc_ok = 1'b0; tick();
    check("R2 drop", por_ready, 0);
    check("R7 low on drop", fault_n, 0);
    check("R8 block on drop", gh_block, 1);
    vcc_ok = 1'b1; repeat (5) tick();
    vcc_ok = 1'b0; tick();
    repower();

    // R3 sweep over the arming inputs
    for (int c = 0; c < 16; c++) begin
      automatic bit g  = c[0];
      automatic bit o  = c[1];
      automatic bit vc = c[2];
      automatic bit vi = c[3];
      automatic int exp = (g && o && vc && vi) ? 1 : 0;
      gh_on = g; oc_cmp = o; vcc_ok = vc; vin_ok = vi; pwm_lvl = PWM_HIGH;
      tick();
      gh_on = 1'b0; oc_cmp = 1'b0;
      check("R3 trip", imon_force, exp);
      check("R3 gh_block", gh_block, (exp == 1 || !vc) ? 1 : 0);
      check("R7 fault_n", fault_n, (exp == 1 || !vc || !vi) ? 0 : 1);
      vin_ok = 1'b1;
      if (exp == 1) ack_clear("R4 sweep ack");
      if (!vc) repower();
      else tick();
      check("R7 back to released", fault_n, 1);
    end

    // R4 interrupted acknowledge, floating code counts as mid
    trip_oc();
    pwm_lvl = PWM_FLOAT;
    repeat (ACK_CYC - 1) tick();
    pwm_lvl = PWM_LOW; tick();
    check("R4 interrupted ack holds", imon_force, 1);
    pwm_lvl = PWM_MID;
    repeat (ACK_CYC - 1) tick();
    check("R4 restarted count holds", imon_force, 1);
    tick();
    check("R4 restarted count clears", imon_force, 0);
    pwm_lvl = PWM_LOW;

    // R4 no acknowledge: stays set with PWM high
    trip_oc();
    pwm_lvl = PWM_HIGH;
    repeat (100) tick();
    check("R4 no ack imon", imon_force, 1);
    check("R3 block with pwm high", gh_block, 1);
    check("R3 fault_n low", fault_n, 0);

    // R9 supply loss clears overcurrent
    vcc_ok = 1'b0; tick();
    check("R9 oc cleared", imon_force, 0);
    pwm_lvl = PWM_LOW;
    repower();
    check("R9 released after repower", fault_n, 1);

    // R5 shorted FET
    sw_hi = 1'b1; gl_on = 1'b0; tick();
    check("R5 sw_hi without gl ignored", imon_force, 0);
    gl_on = 1'b1; tick();
    sw_hi = 1'b0; gl_on = 1'b0;
    check("R5 short latched", imon_force, 1);
    check("R5 short blocks gh", gh_block, 1);
    pwm_lvl = PWM_MID;
    repeat (ACK_CYC + 4) tick();
    check("R5 ack ignored", imon_force, 1);
    check("R5 fault_n low", fault_n, 0);
    pwm_lvl = PWM_LOW;
    vcc_ok = 1'b0; tick();
    check("R5 cleared by supply reset", imon_force, 0);
    repower();
    check("R5 released", fault_n, 1);

    // R6 temperature sweep up then down
    begin
      automatic int ot_exp = 0;
      for (int k = 0; k < 512; k++) begin
        automatic int t = (k < 256) ? k : 511 - k;
        temp_c = 8'(t);
        tick();
        if (t >= 140) ot_exp = 1;
        else if (t < 125) ot_exp = 0;
        check("R6 tmon_force", tmon_force, ot_exp);
        check("R6 no gate action", gh_block, 0);
        check("R7 fault_n with ot", fault_n, ot_exp ? 0 : 1);
      end
    end
    temp_c = 8'd25;

    // R7 input supply dip
    vin_ok = 1'b0; tick();
    check("R7 vin low", fault_n, 0);
    check("R8 vin low no block", gh_block, 0);
    vin_ok = 1'b1; tick();
    check("R7 vin back", fault_n, 1);

    // R1 reset mid-operation
    trip_oc(); tmp_hot();
    rst = 1'b1; tick();
    check("R1 reset clears imon", imon_force, 0);
    check("R1 reset clears tmon", tmon_force, 0);
    check("R1 reset por", por_ready, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic tmp_hot();
    temp_c = 8'd200; tick();
    check("R6 hot", tmon_force, 1);
  endtask
endmodule